// File: doc/BRIEF.md
# Cut-Based Child Pointer Generator

This block sits inside one stage of a pipelined multi-field classification tree. For each packet it computes the memory address of the child node to visit next. The current node cuts some or all of the header fields into a power-of-two number of equal slices, and for each field it stores the log2 of that slice count. The block takes, from each cut field, the bits that lie just below the bits already used by the ancestor nodes, and joins these bit groups into one child index. It then adds the index to the node's base address.

All bit extraction uses a left shift followed by a right shift. There are no multipliers and no dividers, so the path stays short enough to accept one packet on every clock. By default the sum is registered, which gives one cycle of latency. A parameter can select a purely combinational output instead.

Top module: `cut_child_ptr`

## Requirements
- R1: When the registered output is in use, `child_addr` equals `base_addr` plus the joined child index, modulo 2^ADDR_W. A sum past the top of the address space wraps around.
- R2: A field with effective cut width s and consumed offset o contributes field bits [FIELD_W-1-o : FIELD_W-o-s], taken as an unsigned value. Bit FIELD_W-1 is the field's most significant bit.
- R3: A field whose cut log is 0 contributes no bits. It neither changes the index nor shifts the bits of the other fields.
- R4: Field k occupies `hdr_fields[k*FIELD_W +: FIELD_W]`, `cut_log[k*CUT_W +: CUT_W]` and `consumed[k*OFS_W +: OFS_W]`. The bit groups are joined with field 0 most significant and field NUM_FIELDS-1 least significant.
- R5: Bit positions that fall below the field's least significant bit (o+s > FIELD_W) read as zero. This includes the case o >= FIELD_W. Such a field still occupies its s index bits.
- R6: A cut log above MAX_CUT_LOG is treated as MAX_CUT_LOG.
- R7: A request with `in_valid` high at one rising edge gives `out_valid` high with its address after that edge. Back-to-back requests are accepted on every cycle.
- R8: After an edge where `in_valid` was low, `out_valid` is low and `child_addr` keeps its previous value.
- R9: While `rst_n` is low (asynchronous, active low), `out_valid` and `child_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| hdr_fields | input | NUM_FIELDS*FIELD_W | Packed header fields, field k at k*FIELD_W |
| cut_log | input | NUM_FIELDS*CUT_W | Per-field log2 of cut count, 0 = not cut |
| consumed | input | NUM_FIELDS*OFS_W | Per-field count of top bits already used |
| base_addr | input | ADDR_W | Base address of the node's child block |
| out_valid | output | 1 | Result valid |
| child_addr | output | ADDR_W | Child node address |

## Verification
The bench targets these corner cases:

- **Offset plus cut past the least significant bit.** A design that takes bits from the wrong side would return set bits where zeros belong.
- **Offsets of 16 and 31.** A shifter that wraps its shift amount would reuse high field bits.
- **Cut logs of 5 to 7.** A design without saturation would create oversized groups and shift its neighbours out of place.
- **An uncut field between two cut fields.** A design that still reserves room for the uncut field would open a gap in the index.
- **A base near the top of the address space.** A design that mishandles the add would not wrap to a small address.

Random configurations are compared against a model that uses multiplication, modulo and division only, so a shifter error anywhere shows up as a mismatch.

// File: rtl/cut_child_ptr_pkg.sv
package cut_child_ptr_pkg;

   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } cpg_out_mode_e;

   localparam int unsigned CPG_DEF_FIELDS  = 4;
   localparam int unsigned CPG_DEF_FIELD_W = 16;
   localparam int unsigned CPG_DEF_MAX_CUT = 4;
   localparam int unsigned CPG_DEF_ADDR_W  = 16;

endpackage

// File: rtl/cpg_field_slicer.sv
module cpg_field_slicer #(
   parameter int unsigned FIELD_W     = 16,
   parameter int unsigned MAX_CUT_LOG = 4,
   parameter int unsigned CUT_W       = 3,
   parameter int unsigned OFS_W       = 5
) (
   input  logic [FIELD_W-1:0]     field_i,
   input  logic [CUT_W-1:0]       cut_log_i,
   input  logic [OFS_W-1:0]       offset_i,
   output logic [MAX_CUT_LOG-1:0] bits_o,
   output logic [CUT_W-1:0]       width_o
);

   localparam int unsigned SH_W = $clog2(FIELD_W + 1);

   logic [CUT_W-1:0]   width_sat;
   logic [FIELD_W-1:0] aligned;
   logic [FIELD_W-1:0] shifted;
   logic [SH_W-1:0]    rsh;

   // Clamp oversized cut logs to the largest supported group.
   always_comb begin
      if (cut_log_i > CUT_W'(MAX_CUT_LOG)) begin
         width_sat = CUT_W'(MAX_CUT_LOG);
      end else begin
         width_sat = cut_log_i;
      end
   end

   // Left shift drops the consumed bits and fills the bottom with zeros.
   // Right shift then keeps only the top width_sat bits.
   always_comb begin
      aligned = field_i << offset_i;
      rsh     = SH_W'(FIELD_W - int'(width_sat));
      shifted = aligned >> rsh;
   end

   assign bits_o  = shifted[MAX_CUT_LOG-1:0];
   assign width_o = width_sat;

endmodule

// File: rtl/cpg_index_packer.sv
module cpg_index_packer #(
   parameter int unsigned NUM_FIELDS  = 4,
   parameter int unsigned MAX_CUT_LOG = 4,
   parameter int unsigned CUT_W       = 3,
   parameter int unsigned IDX_W       = 16
) (
   input  logic [NUM_FIELDS*MAX_CUT_LOG-1:0] bits_i,
   input  logic [NUM_FIELDS*CUT_W-1:0]       widths_i,
   output logic [IDX_W-1:0]                  index_o
);

   logic [IDX_W-1:0] acc [NUM_FIELDS+1];

   assign acc[0] = '0;

   // Field 0 enters first, so after all shifts it ends up most significant.
   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_join
      assign acc[f+1] = (acc[f] << widths_i[f*CUT_W +: CUT_W])
                      | IDX_W'(bits_i[f*MAX_CUT_LOG +: MAX_CUT_LOG]);
   end

   assign index_o = acc[NUM_FIELDS];

endmodule

// File: rtl/cpg_out_stage.sv
module cpg_out_stage #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned IDX_W  = 16,
   parameter bit          PIPE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [IDX_W-1:0]  index_i,
   output logic              valid_o,
   output logic [ADDR_W-1:0] addr_o
);

   logic [ADDR_W-1:0] sum;

   assign sum = base_i + ADDR_W'(index_i);

   if (PIPE) begin : g_reg
      logic              valid_q;
      logic [ADDR_W-1:0] addr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
         end else begin
            valid_q <= valid_i;
            if (valid_i) begin
               addr_q <= sum;
            end
         end
      end

      assign valid_o = valid_q;
      assign addr_o  = addr_q;
   end else begin : g_comb
      assign valid_o = valid_i;
      assign addr_o  = sum;
   end

endmodule

// File: rtl/cut_child_ptr.sv
module cut_child_ptr
   import cut_child_ptr_pkg::*;
#(
   parameter int unsigned NUM_FIELDS  = CPG_DEF_FIELDS,
   parameter int unsigned FIELD_W     = CPG_DEF_FIELD_W,
   parameter int unsigned MAX_CUT_LOG = CPG_DEF_MAX_CUT,
   parameter int unsigned ADDR_W      = CPG_DEF_ADDR_W,
   parameter bit          PIPE        = OUT_REG,
   localparam int unsigned CUT_W      = $clog2(MAX_CUT_LOG + 1),
   localparam int unsigned OFS_W      = $clog2(FIELD_W) + 1,
   localparam int unsigned IDX_W      = NUM_FIELDS * MAX_CUT_LOG
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [NUM_FIELDS*FIELD_W-1:0] hdr_fields,
   input  logic [NUM_FIELDS*CUT_W-1:0]   cut_log,
   input  logic [NUM_FIELDS*OFS_W-1:0]   consumed,
   input  logic [ADDR_W-1:0]             base_addr,
   output logic                          out_valid,
   output logic [ADDR_W-1:0]             child_addr
);

   // Elaboration-time parameter checks.
   if (NUM_FIELDS < 1) begin : g_chk_fields
      $error("cut_child_ptr: NUM_FIELDS must be at least 1");
   end
   if (MAX_CUT_LOG < 1 || MAX_CUT_LOG > FIELD_W) begin : g_chk_cut
      $error("cut_child_ptr: MAX_CUT_LOG must lie in 1..FIELD_W");
   end
   if (IDX_W > ADDR_W) begin : g_chk_idx
      $error("cut_child_ptr: joined index wider than address");
   end

   logic [NUM_FIELDS*MAX_CUT_LOG-1:0] slice_bits;
   logic [NUM_FIELDS*CUT_W-1:0]       slice_width;
   logic [IDX_W-1:0]                  child_index;

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      cpg_field_slicer #(
         .FIELD_W     (FIELD_W),
         .MAX_CUT_LOG (MAX_CUT_LOG),
         .CUT_W       (CUT_W),
         .OFS_W       (OFS_W)
      ) u_slice (
         .field_i   (hdr_fields[f*FIELD_W +: FIELD_W]),
         .cut_log_i (cut_log[f*CUT_W +: CUT_W]),
         .offset_i  (consumed[f*OFS_W +: OFS_W]),
         .bits_o    (slice_bits[f*MAX_CUT_LOG +: MAX_CUT_LOG]),
         .width_o   (slice_width[f*CUT_W +: CUT_W])
      );
   end

   cpg_index_packer #(
      .NUM_FIELDS  (NUM_FIELDS),
      .MAX_CUT_LOG (MAX_CUT_LOG),
      .CUT_W       (CUT_W),
      .IDX_W       (IDX_W)
   ) u_pack (
      .bits_i   (slice_bits),
      .widths_i (slice_width),
      .index_o  (child_index)
   );

   cpg_out_stage #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .PIPE   (PIPE)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (in_valid),
      .base_i  (base_addr),
      .index_i (child_index),
      .valid_o (out_valid),
      .addr_o  (child_addr)
   );

endmodule

// File: rtl/cut_child_ptr_chk.sv
module cut_child_ptr_chk #(
   parameter int unsigned NUM_FIELDS  = 4,
   parameter int unsigned FIELD_W     = 16,
   parameter int unsigned MAX_CUT_LOG = 4,
   parameter int unsigned ADDR_W      = 16,
   parameter bit          PIPE        = 1'b1,
   parameter int unsigned CUT_W       = 3,
   parameter int unsigned OFS_W       = 5
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        in_valid,
   input logic [NUM_FIELDS*CUT_W-1:0] cut_log,
   input logic [NUM_FIELDS*OFS_W-1:0] consumed,
   input logic [ADDR_W-1:0]           base_addr,
   input logic                        out_valid,
   input logic [ADDR_W-1:0]           child_addr
);

   localparam int unsigned SPAN_W = $clog2(NUM_FIELDS * MAX_CUT_LOG + 1);

   logic              no_cut;
   logic              all_used;
   logic [SPAN_W-1:0] span;
   logic [SPAN_W-1:0] span_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] diff;

   always_comb begin
      no_cut   = 1'b1;
      all_used = 1'b1;
      span     = '0;
      for (int f = 0; f < NUM_FIELDS; f++) begin
         if (cut_log[f*CUT_W +: CUT_W] != '0) begin
            no_cut = 1'b0;
         end
         if (int'(consumed[f*OFS_W +: OFS_W]) < FIELD_W) begin
            all_used = 1'b0;
         end
         if (int'(cut_log[f*CUT_W +: CUT_W]) > MAX_CUT_LOG) begin
            span = span + SPAN_W'(MAX_CUT_LOG);
         end else begin
            span = span + SPAN_W'(cut_log[f*CUT_W +: CUT_W]);
         end
      end
   end

   always_ff @(posedge clk) begin
      base_q <= base_addr;
      span_q <= span;
   end

   assign diff = child_addr - base_q;

   if (PIPE) begin : g_seq
      AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid); // R7
      AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid); // R8
      AST_IDLE_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(child_addr)); // R8
      AST_UNCUT_GIVES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && no_cut) |=> (child_addr == $past(base_addr))); // R3
      AST_SPENT_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && all_used) |=> (child_addr == $past(base_addr))); // R5
      AST_INDEX_WITHIN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> ((diff >> span_q) == '0)); // R6
   end

endmodule

bind cut_child_ptr cut_child_ptr_chk #(
   .NUM_FIELDS  (NUM_FIELDS),
   .FIELD_W     (FIELD_W),
   .MAX_CUT_LOG (MAX_CUT_LOG),
   .ADDR_W      (ADDR_W),
   .PIPE        (PIPE),
   .CUT_W       (CUT_W),
   .OFS_W       (OFS_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .cut_log    (cut_log),
   .consumed   (consumed),
   .base_addr  (base_addr),
   .out_valid  (out_valid),
   .child_addr (child_addr)
);

// File: tb/test_cut_child_ptr.sv
`timescale 1ns/1ps
module test_cut_child_ptr;

   localparam int NF = 4;
   localparam int FW = 16;
   localparam int MC = 4;
   localparam int AW = 16;
   localparam int CW = 3;
   localparam int OW = 5;

   typedef struct packed {
      logic [NF*FW-1:0] flds;
      logic [NF*CW-1:0] cuts;
      logic [NF*OW-1:0] offs;
      logic [AW-1:0]    base;
      logic [AW-1:0]    expv;
   } vec_t;

   // Field order inside each concatenation: {field3, field2, field1, field0}.
   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      // R3: nothing cut, result is the base
      '{ {16'h5555,16'hAAAA,16'h1234,16'hFFFF}, {3'd0,3'd0,3'd0,3'd0},
         {5'd3,5'd2,5'd1,5'd0}, 16'h1234, 16'h1234 },
      // R2: top nibble of field 0
      '{ {16'h0000,16'h0000,16'h0000,16'hA000}, {3'd0,3'd0,3'd0,3'd4},
         {5'd0,5'd0,5'd0,5'd0}, 16'h0100, 16'h010A },
      // R2 R4: offset 4 nibble of f0, then one bit of f1
      '{ {16'h0000,16'h0000,16'h8000,16'hABCD}, {3'd0,3'd0,3'd1,3'd4},
         {5'd0,5'd0,5'd0,5'd4}, 16'h0000, 16'h0017 },
      // R4: all four fields give one nibble each
      '{ {16'h4000,16'h3000,16'h2000,16'h1000}, {3'd4,3'd4,3'd4,3'd4},
         {5'd0,5'd0,5'd0,5'd0}, 16'h1000, 16'h2234 },
      // R5: offset 14 with 4 cut bits runs past the LSB
      '{ {16'h0000,16'h0000,16'h0000,16'h000F}, {3'd0,3'd0,3'd0,3'd4},
         {5'd0,5'd0,5'd0,5'd14}, 16'h0000, 16'h000C },
      // R6: cut log 7 behaves as 4
      '{ {16'h0000,16'h0000,16'h0000,16'hF000}, {3'd0,3'd0,3'd0,3'd7},
         {5'd0,5'd0,5'd0,5'd0}, 16'h0005, 16'h0014 },
      // R5: field 0 fully consumed (offset 16) still holds its slot
      '{ {16'h0000,16'h0000,16'hC000,16'hFFFF}, {3'd0,3'd0,3'd2,3'd4},
         {5'd0,5'd0,5'd0,5'd16}, 16'h0010, 16'h0013 },
      // R5: offset 31
      '{ {16'h0000,16'h0000,16'hC000,16'hFFFF}, {3'd0,3'd0,3'd2,3'd4},
         {5'd0,5'd0,5'd0,5'd31}, 16'h0010, 16'h0013 },
      // R1: sum wraps past the top of the address space
      '{ {16'h2000,16'h0000,16'h0000,16'h1000}, {3'd4,3'd0,3'd0,3'd4},
         {5'd0,5'd0,5'd0,5'd0}, 16'hFFF0, 16'h0002 },
      // R3: uncut field 1 between cut fields leaves no gap
      '{ {16'h0000,16'h4000,16'hFFFF,16'h8000}, {3'd0,3'd2,3'd0,3'd1},
         {5'd0,5'd0,5'd0,5'd0}, 16'h0000, 16'h0005 }
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [NF*FW-1:0] hdr_fields = '0;
   logic [NF*CW-1:0] cut_log = '0;
   logic [NF*OW-1:0] consumed = '0;
   logic [AW-1:0] base_addr = '0;
   logic          out_valid;
   logic [AW-1:0] child_addr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cut_child_ptr i_cut_child_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .hdr_fields (hdr_fields),
      .cut_log    (cut_log),
      .consumed   (consumed),
      .base_addr  (base_addr),
      .out_valid  (out_valid),
      .child_addr (child_addr)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // Reference model: division and modulo on wide integers, no shifters.
   function automatic logic [AW-1:0] model(logic [NF*FW-1:0] f, logic [NF*CW-1:0] c,
                                           logic [NF*OW-1:0] o, logic [AW-1:0] b);
      longint idx = 0;
      for (int i = 0; i < NF; i++) begin
         longint s  = longint'(c[i*CW +: CW]);
         longint fv = longint'(f[i*FW +: FW]);
         longint ov = longint'(o[i*OW +: OW]);
         longint bits;
         if (s > MC) s = MC;
         if (s == 0) bits = 0;
         else bits = ((fv * (longint'(2) ** ov)) % 65536) / (longint'(2) ** (16 - s));
         idx = idx * (longint'(2) ** s) + bits;
      end
      return AW'((longint'(b) + idx) % 65536);
   endfunction

   task automatic apply(logic [NF*FW-1:0] f, logic [NF*CW-1:0] c,
                        logic [NF*OW-1:0] o, logic [AW-1:0] b);
      hdr_fields = f;
      cut_log    = c;
      consumed   = o;
      base_addr  = b;
      in_valid   = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [AW-1:0] held;
      repeat (3) @(negedge clk);
      check("R9 reset out_valid", 32'(out_valid), 32'd0);
      check("R9 reset child_addr", 32'(child_addr), 32'd0);
      rst_n = 1'b1;

      // Table walk, back to back: each result is checked one cycle later (R7).
      @(negedge clk);
      for (int v = 0; v < NV; v++) begin
         apply(VECS[v].flds, VECS[v].cuts, VECS[v].offs, VECS[v].base);
         @(negedge clk);
         check("R7 out_valid after request", 32'(out_valid), 32'd1);
         check($sformatf("R1 R2 R4 vector %0d", v), 32'(child_addr), 32'(VECS[v].expv));
      end

      // Random configurations against the division model (R1 R2 R3 R4 R5 R6).
      for (int n = 0; n < 400; n++) begin
         logic [NF*FW-1:0] f;
         logic [NF*CW-1:0] c;
         logic [NF*OW-1:0] o;
         logic [AW-1:0]    b;
         f = {$urandom, $urandom};
         c = NF*CW'($urandom);
         for (int i = 0; i < NF; i++) o[i*OW +: OW] = OW'($urandom_range(0, 20));
         b = AW'($urandom);
         apply(f, c, o, b);
         @(negedge clk);
         check("R2 random vs model", 32'(child_addr), 32'(model(f, c, o, b)));
      end

      // R8: idle cycle, inputs change, output holds.
      held = child_addr;
      in_valid = 1'b0;
      hdr_fields = '1;
      cut_log = '1;
      base_addr = 16'h7777;
      @(negedge clk);
      check("R8 idle out_valid", 32'(out_valid), 32'd0);
      check("R8 idle holds child_addr", 32'(child_addr), 32'(held));
      @(negedge clk);
      check("R8 second idle holds", 32'(child_addr), 32'(held));

      // R9: asynchronous reset in mid run.
      apply(VECS[3].flds, VECS[3].cuts, VECS[3].offs, VECS[3].base);
      @(negedge clk);
      check("R7 before reset", 32'(child_addr), 32'(VECS[3].expv));
      in_valid = 1'b0;
      #3 rst_n = 1'b0;
      #2;
      check("R9 async reset out_valid", 32'(out_valid), 32'd0);
      check("R9 async reset child_addr", 32'(child_addr), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 stays clear after release", 32'(child_addr), 32'd0);

      finish_run();
   end

endmodule